// File: doc/BRIEF.md
# Conflict-Triggered Instruction Cache

This block is a small two-way instruction store for a DSP core with a three-stage fetch, decode and execute pipeline and a single program-memory bus. That bus carries instruction fetches and, now and then, data transfers made by the executing instruction. The store is consulted only in cycles where such a data transfer and an instruction fetch meet on the program bus. In every other cycle the core fetches straight from program memory and the store is neither read nor changed.

In a conflict cycle the address being fetched is looked up. This is the instruction two slots behind the one doing the transfer. On a hit the stored instruction is handed to the core at once, so the fetch and the data transfer finish in the same cycle. On a miss the block raises a one-cycle stall. In the next cycle program memory serves the fetch, and the block captures that word into the set. It chooses a free way first; if both ways are full, it replaces the least recently used one. A freeze input keeps the contents fixed. One-cycle hit, fill and evict pulses let a monitor count cache traffic and thrashing.

Top module: `cti_cache`

## Requirements
- R1: After reset every entry is invalid, so the first conflict lookup of any address misses, and hit, stall, fill and evict are all low.
- R2: A cycle with `pm_conflict` low gives no hit and no stall, drives `instr` to zero and leaves the cache contents unchanged.
- R3: The set is `fetch_addr[3:0]` and the tag is the remaining upper bits. Two addresses with the same low four bits but different upper bits can be held together in one set, and addresses in different sets do not disturb each other.
- R4: A conflict lookup that matches a valid entry raises `hit` in that same cycle, with `instr` equal to the stored word and `stall` low.
- R5: A conflict lookup that misses raises `stall` for that one cycle. In the next cycle `fill` is high, and the `mem_rdata` value of that cycle is written as the entry for the missed address.
- R6: A fill into a set that still has an invalid way uses that way and keeps `evict` low.
- R7: Each set has one LRU bit. A hit or a fill makes that way the most recently used. A fill into a set whose two ways are both valid replaces the least recently used way and raises `evict` together with `fill`.
- R8: While `freeze` is high at a missing lookup, `stall` still rises, but no fill follows and the contents stay unchanged. Hits are still served while frozen.
- R9: In the fill cycle right after a miss, a conflict lookup is ignored: `hit` and `stall` stay low.
- R10: `hit`, `stall`, `fill` and `evict` are single-cycle pulses for each event. Three addresses that share one set and are looked up in turn miss on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_conflict | input | 1 | Data transfer and instruction fetch share the program bus this cycle |
| fetch_addr | input | AW | Address of the instruction fetched this cycle |
| mem_rdata | input | IW | Instruction word from program memory, captured in the fill cycle |
| freeze | input | 1 | Blocks all writes and replacements in the cache |
| hit | output | 1 | Conflict lookup found the instruction |
| instr | output | IW | Cached instruction while `hit` is high, zero otherwise |
| stall | output | 1 | Conflict lookup missed; core holds for one cycle |
| fill | output | 1 | An entry is written this cycle |
| evict | output | 1 | The fill this cycle overwrites a valid entry |

## Verification
A corrupted tag, valid bit or data word shows up at the next conflict lookup of that set: a hit turns into a stall, or `instr` carries the wrong word in that same cycle. A wrong LRU bit stays hidden until the set is full. It then appears at the next fill as an eviction of the wrong way, and the following lookups of the two older addresses show it as a hit and a stall swapped. The directed sequences therefore fill sets, touch one way and then force a replacement, so that stale replacement state reaches the ports within a few cycles.

// File: rtl/cti_cache.sv
module cti_cache #(
  parameter int AW   = 16,
  parameter int IW   = 24,
  parameter int SETS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_conflict,
  input  logic [AW-1:0] fetch_addr,
  input  logic [IW-1:0] mem_rdata,
  input  logic          freeze,
  output logic          hit,
  output logic [IW-1:0] instr,
  output logic          stall,
  output logic          fill,
  output logic          evict
);
  localparam int IXW = $clog2(SETS);
  localparam int TW  = AW - IXW;

  logic [TW-1:0]   tag_q [2][SETS];
  logic [IW-1:0]   dat_q [2][SETS];
  logic [SETS-1:0] val_q [2];
  logic [SETS-1:0] lru_q;
  logic            pend_q;
  logic [AW-1:0]   paddr_q;

  logic [IXW-1:0] idx, pidx;
  logic [TW-1:0]  tg, ptg;
  logic           h0, h1, look, pv0, pv1, victim;

  assign idx  = fetch_addr[IXW-1:0];
  assign tg   = fetch_addr[AW-1:IXW];
  assign pidx = paddr_q[IXW-1:0];
  assign ptg  = paddr_q[AW-1:IXW];

  assign h0   = val_q[0][idx] && (tag_q[0][idx] == tg);
  assign h1   = val_q[1][idx] && (tag_q[1][idx] == tg);
  assign look = pm_conflict && !pend_q;

  assign hit   = look && (h0 || h1);
  assign stall = look && !(h0 || h1);
  assign instr = !hit ? '0 : (h1 ? dat_q[1][idx] : dat_q[0][idx]);

  assign pv0    = val_q[0][pidx];
  assign pv1    = val_q[1][pidx];
  assign victim = !pv0 ? 1'b0 : (!pv1 ? 1'b1 : lru_q[pidx]);
  assign fill   = pend_q;
  assign evict  = pend_q && pv0 && pv1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q[0] <= '0;
      val_q[1] <= '0;
      lru_q    <= '0;
      pend_q   <= 1'b0;
      paddr_q  <= '0;
    end else begin
      pend_q <= stall && !freeze;
      if (stall) paddr_q <= fetch_addr;
      if (hit) lru_q[idx] <= h0;
      if (pend_q) begin
        val_q[victim][pidx] <= 1'b1;
        lru_q[pidx]         <= ~victim;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q) begin
      tag_q[victim][pidx] <= ptg;
      dat_q[victim][pidx] <= mem_rdata;
    end
  end
endmodule

module cti_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic pm_conflict,
  input logic freeze,
  input logic hit,
  input logic stall,
  input logic fill,
  input logic evict
);
  // R4
  hit_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && stall));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_conflict |-> (!hit && !stall));
  // R5
  fill_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !freeze) |=> fill);
  // R8
  frozen_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && freeze) |=> !fill);
  // R7
  evict_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> fill);
  // R9
  fill_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> (!hit && !stall));
  // R10
  fill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> !fill);
  // R10
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !freeze) |=> !stall);
endmodule

bind cti_cache cti_cache_chk u_chk (.*);

// File: tb/cti_cache_test.sv
`timescale 1ns/1ps
module cti_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_conflict = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [23:0] mem_rdata = '0;
  logic        freeze = 1'b0;
  logic        hit, stall, fill, evict;
  logic [23:0] instr;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cti_cache uut (.clk(clk), .rst_n(rst_n), .pm_conflict(pm_conflict),
    .fetch_addr(fetch_addr), .mem_rdata(mem_rdata), .freeze(freeze),
    .hit(hit), .instr(instr), .stall(stall), .fill(fill), .evict(evict));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [15:0] a, input logic [23:0] d, input logic f);
    @(negedge clk);
    pm_conflict = c; fetch_addr = a; mem_rdata = d; freeze = f;
    #1;
  endtask

  function automatic logic [23:0] word(input logic [15:0] a);
    return {8'hC5, a ^ 16'h3A5A};
  endfunction

  task automatic miss_fill(input logic [15:0] a, input logic exp_evict, input string req);
    drive(1, a, 24'h0, 0);
    chk({req, " stall"}, stall, 1); chk({req, " hit"}, hit, 0);
    drive(0, a + 16'd1, word(a), 0);
    chk({req, " fill"}, fill, 1); chk({req, " evict"}, evict, exp_evict);
    chk({req, " stall gone"}, stall, 0);
  endtask

  task automatic look_hit(input logic [15:0] a, input string req);
    drive(1, a, 24'h0, 0);
    chk({req, " hit"}, hit, 1); chk({req, " instr"}, instr, word(a));
    chk({req, " stall"}, stall, 0);
  endtask

  task automatic t_reset;
    drive(0, 16'h0003, 0, 0);
    chk("R1 hit", hit, 0); chk("R1 stall", stall, 0);
    chk("R1 fill", fill, 0); chk("R1 evict", evict, 0);
    miss_fill(16'h0003, 0, "R1 first lookup");
  endtask

  task automatic t_basic;
    look_hit(16'h0003, "R4");
    drive(0, 16'h0004, 0, 0);
    chk("R5 fill pulse ends", fill, 0);
  endtask

  task automatic t_idle;
    drive(0, 16'h0003, 0, 0);
    chk("R2 hit", hit, 0); chk("R2 stall", stall, 0); chk("R2 instr", instr, 0);
    drive(0, 16'h0044, 24'h123456, 0);
    drive(0, 16'h0045, 24'h654321, 0);
    chk("R2 no fill", fill, 0);
    miss_fill(16'h0044, 0, "R2 untouched");
    look_hit(16'h0044, "R2 after fill");
  endtask

  task automatic t_index;
    miss_fill(16'h0005, 0, "R3 way a");
    miss_fill(16'h0105, 0, "R6 way b");
    miss_fill(16'h0006, 0, "R3 other set");
    look_hit(16'h0005, "R3 a kept");
    look_hit(16'h0105, "R3 b kept");
    look_hit(16'h0006, "R3 set6");
  endtask

  task automatic t_lru;
    miss_fill(16'h0002, 0, "R6 set2 a");
    miss_fill(16'h0012, 0, "R6 set2 b");
    look_hit(16'h0002, "R7 touch a");
    miss_fill(16'h0022, 1, "R7 replace b");
    look_hit(16'h0002, "R7 a survives");
    look_hit(16'h0022, "R7 c present");
    drive(1, 16'h0012, 0, 0);
    chk("R7 b gone", stall, 1);
    drive(0, 16'h0000, word(16'h0012), 0);
    chk("R7 b refill evicts", evict, 1);
    look_hit(16'h0012, "R7 b back");
    look_hit(16'h0022, "R7 c kept");
    drive(1, 16'h0002, 0, 0);
    chk("R7 lru a evicted", stall, 1);
    drive(0, 16'h0000, word(16'h0002), 0);
  endtask

  task automatic t_freeze;
    miss_fill(16'h0009, 0, "R8 setup");
    drive(1, 16'h0019, 0, 1);
    chk("R8 frozen stall", stall, 1);
    drive(0, 16'h001A, 24'hBADBAD, 1);
    chk("R8 no fill", fill, 0);
    drive(1, 16'h0009, 0, 1);
    chk("R8 frozen hit", hit, 1); chk("R8 frozen instr", instr, word(16'h0009));
    drive(1, 16'h0019, 0, 0);
    chk("R8 still absent", stall, 1);
    drive(0, 16'h0000, word(16'h0019), 0);
    chk("R8 fill after thaw", fill, 1); chk("R8 free way", evict, 0);
    look_hit(16'h0019, "R8 filled");
  endtask

  task automatic t_fill_cycle;
    drive(1, 16'h000A, 0, 0);
    chk("R9 miss", stall, 1);
    drive(1, 16'h0003, word(16'h000A), 0);
    chk("R9 fill", fill, 1); chk("R9 hit blocked", hit, 0);
    chk("R9 stall blocked", stall, 0);
    look_hit(16'h000A, "R9 stored");
    look_hit(16'h0003, "R9 other intact");
  endtask

  task automatic t_thrash;
    int ev = 0;
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] a;
        a = 16'h000C + 16'(k) * 16'h0010;
        drive(1, a, 0, 0);
        chk("R10 thrash miss", stall, 1);
        drive(0, 16'h0000, word(a), 0);
        chk("R10 thrash fill", fill, 1);
        if (evict) ev++;
        drive(0, 16'h0000, 0, 0);
        chk("R10 fill single", fill, 0); chk("R10 evict single", evict, 0);
      end
    end
    chk("R10 evict count", ev, 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_basic;
    t_idle;
    t_index;
    t_lru;
    t_freeze;
    t_fill_cycle;
    t_thrash;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule